// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline, so a taken branch costs one lost fetch slot rather than three. It holds the fetch/decode pipeline register. Each cycle it tests the two source operands that the register file delivers in decode for equality. It also forms the branch destination with its own adder, from the instruction's incremented PC and its sign-extended word offset. From those results it steers the next fetch address and squashes the wrong-path instruction that was fetched behind the branch.

Fetch always runs ahead on the fall-through path. When the decoded instruction is an equal-branch whose operands match, or an unequal-branch whose operands differ, the block selects the computed destination as the next fetch address. In the same cycle it raises a flush, which loads a nop into the fetch/decode register in place of the fall-through instruction. A stall input from the load-use hazard logic freezes the fetch address and the fetch/decode register. While a stall is raised the branch stays in decode unresolved, and it resolves in the first cycle without a stall.

Top module: `bru_decode_resolve`

## Requirements
- R1: While reset is asserted and after it is released, the instruction in decode is the nop word 32'h0000_0000, and with a nop in decode `pc_sel` and `flush` are 0 and `next_pc` equals `if_pc + 4`.
- R2: The decode opcode is bits [31:26]. Opcode 6'h04 is taken when `rs_data == rt_data`, opcode 6'h05 is taken when they differ, and every other opcode is never taken, whatever the operands are.
- R3: The branch destination is the decode instruction's PC+4 plus the sign-extended bits [15:0] shifted left by two. This holds for negative and zero offsets.
- R4: With no taken branch and no stall, `next_pc` equals `if_pc + 4`, and `pc_sel` and `flush` are 0.
- R5: For a taken branch without a stall, `pc_sel` and `flush` are 1 and `next_pc` equals the destination, all in the same cycle. On the next edge the decode instruction becomes the nop word, whatever is being fetched.
- R6: In a cycle with neither flush nor stall, the next edge loads `if_instr` into decode and loads `if_pc + 4` as its PC+4.
- R7: While `stall_i` is 1, `next_pc` equals `if_pc`, `pc_sel` and `flush` are 0 even when a taken branch is in decode, and the decode instruction and PC+4 are held. The branch resolves in the first cycle after `stall_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_pc | input | AW | Address of the instruction being fetched |
| if_instr | input | 32 | Instruction being fetched |
| stall_i | input | 1 | Load-use stall: hold fetch and decode |
| rs_data | input | DW | First source operand read in decode |
| rt_data | input | DW | Second source operand read in decode |
| next_pc | output | AW | Address to fetch on the next cycle |
| pc_sel | output | 1 | 1 selects the branch destination, 0 the fall-through or held address |
| flush | output | 1 | Squash the fetched instruction into a nop |
| id_instr | output | 32 | Instruction held in the fetch/decode register |
| id_pc_plus4 | output | AW | PC+4 of the instruction in decode |

## Verification
A wrong value captured in the fetch/decode register shows up on `id_instr` one edge after the cycle that loaded it. It also shows up in that same cycle as a wrong `pc_sel`, `flush` or `next_pc`, because all three depend combinationally on the decode opcode, offset and PC+4. A missed squash leaves the fall-through word visible in decode right after a taken branch. A stall that fails to hold shows up on the edge after the stall as a changed decode instruction, or as a branch that resolves too early. The directed scenarios sample the combinational outputs in the resolving cycle and the register contents one edge later, so each such fault is reported within two cycles of its cause.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int INSTR_W = 32;
  localparam int IMM_W   = 16;

  localparam logic [5:0]         OP_BR_EQ = 6'h04;
  localparam logic [5:0]         OP_BR_NE = 6'h05;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  typedef enum logic [1:0] {
    BRK_NONE = 2'd0,
    BRK_EQ   = 2'd1,
    BRK_NE   = 2'd2
  } br_kind_e;

  function automatic br_kind_e classify_op(input logic [5:0] op);
    br_kind_e k;
    case (op)
      OP_BR_EQ: k = BRK_EQ;
      OP_BR_NE: k = BRK_NE;
      default:  k = BRK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/bru_ifid_reg.sv
module bru_ifid_reg
  import bru_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic               squash_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [AW-1:0]      pc4_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic [AW-1:0]      pc4_o
);

  logic [INSTR_W-1:0] instr_q, instr_d;
  logic [AW-1:0]      pc4_q, pc4_d;
  logic               load_en;

  // the register only updates when not held; squash picks the nop word
  assign load_en = ~hold_i;

  always_comb begin
    instr_d = instr_i;
    pc4_d   = pc4_i;
    if (squash_i) begin
      instr_d = NOP_WORD;
      pc4_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= NOP_WORD;
      pc4_q   <= '0;
    end else if (load_en) begin
      instr_q <= instr_d;
      pc4_q   <= pc4_d;
    end
  end

  assign instr_o = instr_q;
  assign pc4_o   = pc4_q;

  // R5
  squash_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_i && !hold_i) |=> (instr_o == NOP_WORD));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(instr_o) && $stable(pc4_o)));

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !squash_i) |=> (instr_o == $past(instr_i)));

endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [5:0]    op_i,
  input  logic [DW-1:0] rs_i,
  input  logic [DW-1:0] rt_i,
  input  logic          hold_i,
  output logic          taken_o
);

  br_kind_e      kind;
  logic [DW-1:0] diff;
  logic          is_zero;

  assign kind    = classify_op(op_i);
  assign diff    = rs_i ^ rt_i;
  assign is_zero = ~|diff;

  always_comb begin
    unique case (kind)
      BRK_EQ:  taken_o = is_zero  & ~hold_i;
      BRK_NE:  taken_o = ~is_zero & ~hold_i;
      default: taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    pc4_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [AW-1:0]    target_o
);

  localparam int SHIFTED_W = IMM_W + 2;

  logic [SHIFTED_W-1:0] off_words;
  logic [AW-1:0]        off_ext;

  assign off_words = {imm_i, 2'b00};

  generate
    if (AW > SHIFTED_W) begin : g_extend
      assign off_ext = {{(AW-SHIFTED_W){imm_i[IMM_W-1]}}, off_words};
    end else begin : g_trunc
      assign off_ext = off_words[AW-1:0];
    end
  endgenerate

  assign target_o = pc4_i + off_ext;

endmodule

// File: rtl/bru_decode_resolve.sv
module bru_decode_resolve
  import bru_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      if_pc,
  input  logic [INSTR_W-1:0] if_instr,
  input  logic               stall_i,
  input  logic [DW-1:0]      rs_data,
  input  logic [DW-1:0]      rt_data,
  output logic [AW-1:0]      next_pc,
  output logic               pc_sel,
  output logic               flush,
  output logic [INSTR_W-1:0] id_instr,
  output logic [AW-1:0]      id_pc_plus4
);

  localparam logic [AW-1:0] PC_STEP = AW'(4);

  logic [AW-1:0] if_pc4;
  logic [AW-1:0] br_target;
  logic          br_taken;

  assign if_pc4 = if_pc + PC_STEP;

  bru_ifid_reg #(.AW(AW)) u_ifid (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (stall_i),
    .squash_i (br_taken),
    .instr_i  (if_instr),
    .pc4_i    (if_pc4),
    .instr_o  (id_instr),
    .pc4_o    (id_pc_plus4)
  );

  bru_cond #(.DW(DW)) u_cond (
    .op_i    (id_instr[31:26]),
    .rs_i    (rs_data),
    .rt_i    (rt_data),
    .hold_i  (stall_i),
    .taken_o (br_taken)
  );

  bru_target #(.AW(AW)) u_target (
    .pc4_i    (id_pc_plus4),
    .imm_i    (id_instr[IMM_W-1:0]),
    .target_o (br_target)
  );

  always_comb begin
    if (stall_i)       next_pc = if_pc;
    else if (br_taken) next_pc = br_target;
    else               next_pc = if_pc4;
  end

  assign pc_sel = br_taken;
  assign flush  = br_taken;

  // R7
  stall_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (!flush && !pc_sel && next_pc == if_pc));

  // R2
  flush_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (id_instr[31:27] == 5'b00010));

  // R4
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_sel && !stall_i) |-> (next_pc == if_pc + PC_STEP));

  // R1
  reset_nop_chk: assert property (@(posedge clk)
    !rst_n |=> (id_instr == NOP_WORD));

endmodule

// File: tb/bru_decode_resolve_bench.sv
module bru_decode_resolve_bench;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] if_pc;
  logic [31:0]   if_instr;
  logic          stall_i;
  logic [DW-1:0] rs_data, rt_data;
  logic [AW-1:0] next_pc, id_pc_plus4;
  logic          pc_sel, flush;
  logic [31:0]   id_instr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  bru_decode_resolve #(.AW(AW), .DW(DW)) u_bru_decode_resolve (
    .clk(clk), .rst_n(rst_n), .if_pc(if_pc), .if_instr(if_instr),
    .stall_i(stall_i), .rs_data(rs_data), .rt_data(rt_data),
    .next_pc(next_pc), .pc_sel(pc_sel), .flush(flush),
    .id_instr(id_instr), .id_pc_plus4(id_pc_plus4)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd2, imm};
  endfunction

  function automatic logic [31:0] dest(input logic [31:0] pc4, input logic [15:0] imm);
    return pc4 + ({{16{imm[15]}}, imm} << 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // place instr at fetch address pc into decode; drive a filler into fetch
  task automatic to_decode(input logic [31:0] ins, input logic [31:0] pc);
    if_instr = ins; if_pc = pc; stall_i = 1'b0;
    @(posedge clk); #1;
    if_instr = 32'h0123_4567; if_pc = pc + 4;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; stall_i = 1'b0; if_pc = 32'h100; if_instr = 32'hFFFF_FFFF;
    rs_data = '0; rt_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 nop in reset", id_instr, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    if_instr = 32'h0;
    @(posedge clk); #1;
    chk("R1 nop after release", id_instr, 32'h0);
    chk("R1 next_pc", next_pc, 32'h104);
    chk("R1 flush", {31'b0, flush}, 32'h0);
  endtask

  task automatic t_eq_taken;
    rs_data = 32'd5; rt_data = 32'd5;
    to_decode(mk(6'h04, 16'd3), 32'h40);
    chk("R2 eq taken pc_sel", {31'b0, pc_sel}, 32'h1);
    chk("R3 eq target", next_pc, dest(32'h44, 16'd3));
    chk("R5 flush", {31'b0, flush}, 32'h1);
    @(posedge clk); #1;
    chk("R5 squashed to nop", id_instr, 32'h0);
  endtask

  task automatic t_eq_not;
    rs_data = 32'd5; rt_data = 32'd6;
    to_decode(mk(6'h04, 16'd3), 32'h80);
    chk("R4 next_pc fall-through", next_pc, 32'h88);
    chk("R4 no flush", {31'b0, flush}, 32'h0);
    @(posedge clk); #1;
    chk("R6 capture instr", id_instr, 32'h0123_4567);
    chk("R6 capture pc4", id_pc_plus4, 32'h88);
  endtask

  task automatic t_ne_taken_neg;
    rs_data = 32'd1; rt_data = 32'd2;
    to_decode(mk(6'h05, 16'hFFFE), 32'h100);
    chk("R2 ne taken", {31'b0, pc_sel}, 32'h1);
    chk("R3 negative offset", next_pc, 32'hFC);
    @(posedge clk); #1;
    chk("R5 nop after ne", id_instr, 32'h0);
  endtask

  task automatic t_ne_not_and_zero_off;
    rs_data = 32'hAAAA_5555; rt_data = 32'hAAAA_5555;
    to_decode(mk(6'h05, 16'd9), 32'h200);
    chk("R2 ne equal not taken", {31'b0, pc_sel}, 32'h0);
    chk("R4 ne fall-through", next_pc, 32'h208);
    to_decode(mk(6'h04, 16'd0), 32'h300);
    chk("R3 zero offset", next_pc, 32'h304);
    chk("R5 zero offset flushes", {31'b0, flush}, 32'h1);
  endtask

  task automatic t_other_op;
    rs_data = 32'd7; rt_data = 32'd7;
    to_decode(mk(6'h06, 16'd5), 32'h400);
    chk("R2 other opcode", {31'b0, pc_sel}, 32'h0);
    to_decode(mk(6'h00, 16'd5), 32'h500);
    chk("R2 opcode zero", next_pc, 32'h508);
  endtask

  task automatic t_stall;
    rs_data = 32'd3; rt_data = 32'd3;
    to_decode(mk(6'h04, 16'd4), 32'h600);
    stall_i = 1'b1; #1;
    chk("R7 stall holds pc", next_pc, 32'h604);
    chk("R7 no flush in stall", {30'b0, pc_sel, flush}, 32'h0);
    @(posedge clk); #1;
    chk("R7 decode held", id_instr, mk(6'h04, 16'd4));
    stall_i = 1'b0; #1;
    chk("R7 resolves after stall", next_pc, dest(32'h604, 16'd4));
    chk("R7 flush after stall", {31'b0, flush}, 32'h1);
    @(posedge clk); #1;
    chk("R7 nop after release", id_instr, 32'h0);
  endtask

  initial begin
    t_reset();
    t_eq_taken();
    t_eq_not();
    t_ne_taken_neg();
    t_ne_not_and_zero_off();
    t_other_op();
    t_stall();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule